// File: doc/BRIEF.md
# Programmable RGB Panel Timing Generator

This block produces the raster timing for a parallel RGB panel: horizontal sync, vertical sync, data enable and the zero-based coordinates of the pixel being shown. Each line is built from four phases in a fixed order: sync pulse, back porch, active pixels, front porch. A frame is built from lines in the same order. Every phase length is programmed as its count minus one. A clock divider turns the source clock into pixel periods. It can be bypassed for 1:1 operation.

The divider setting and a frame-level enable bit form a deferred group. It is captured when the raster starts and again at each frame boundary, so a frame never changes rate part way through. A second, immediate enable bit stops the raster at once. Each sync and enable output has its own polarity inversion bit. A frame interrupt can be raised on entry to a selectable line: the sync start, the first back-porch line, the first active line or the first front-porch line. Its pending flag is cleared by a one-cycle acknowledge strobe.

Top module: `lcd_timing_gen`

## Requirements
- R1: With the raster running, a line lasts (hsw_m1+1)+(hbp_m1+1)+(hact_m1+1)+(hfp_m1+1) pixel periods. Raw horizontal sync is high for the first hsw_m1+1 of them. Back porch follows, then active pixels, then front porch.
- R2: A frame lasts (vsw_m1+1)+(vbp_m1+1)+(vact_m1+1)+(vfp_m1+1) lines. Raw vertical sync is high during the first vsw_m1+1 lines. Back porch, active and front-porch lines follow in that order.
- R3: Raw data enable is high only where both the horizontal and vertical positions are in their active phases. In that case pix_x and pix_y give the 0-based column and row within the active area. When data enable is low, both are 0.
- R4: When div_sel is 1, each pixel position lasts div_m1+1 source cycles. When div_sel is 0, each pixel position lasts one source cycle.
- R5: div_m1 and div_sel are captured only when the raster starts and at each frame wrap. A change made mid-frame first affects the next frame.
- R6: Setting hs_inv, vs_inv or de_inv to 1 inverts the matching output, including while idle.
- R7: From idle, the raster starts at position (0,0) one cycle after en_now and en_frm are both high. When en_now is 0 at a clock edge, the raster stops at that edge: outputs go to their inactive level and the coordinates go to 0.
- R8: When en_frm is 0 at the end of the last pixel of a frame, the raster stops there, and only there. The current frame always completes.
- R9: The frame event fires when the raster enters pixel 0 of a selected line. irq_sel 0 selects line 0 (sync start, which includes the start from idle). irq_sel 1 selects the first back-porch line, 2 the first active line and 3 the first front-porch line.
- R10: The frame event sets irq_pend only when irq_glb_en and irq_frm_en are both 1. The irq output is irq_pend ANDed with both enables.
- R11: irq_ack high for one cycle clears irq_pend. A frame event in the same cycle takes priority and leaves irq_pend set.
- R12: After reset the raster is idle, raw sync and enable are low, the coordinates are 0 and irq_pend is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsw_m1 | input | FW | Horizontal sync width minus one |
| hbp_m1 | input | FW | Horizontal back porch minus one |
| hact_m1 | input | FW | Active pixels per line minus one |
| hfp_m1 | input | FW | Horizontal front porch minus one |
| vsw_m1 | input | FW | Vertical sync width in lines minus one |
| vbp_m1 | input | FW | Vertical back porch in lines minus one |
| vact_m1 | input | FW | Active lines minus one |
| vfp_m1 | input | FW | Vertical front porch in lines minus one |
| div_m1 | input | DW | Pixel clock divisor minus one (deferred) |
| div_sel | input | 1 | 1 enables the divider, 0 selects 1:1 (deferred) |
| hs_inv | input | 1 | Invert horizontal sync |
| vs_inv | input | 1 | Invert vertical sync |
| de_inv | input | 1 | Invert data enable |
| en_now | input | 1 | Immediate enable |
| en_frm | input | 1 | Frame-boundary enable |
| irq_glb_en | input | 1 | Global interrupt enable |
| irq_frm_en | input | 1 | Frame interrupt enable |
| irq_sel | input | 2 | Frame event line select |
| irq_ack | input | 1 | Write-one-to-clear strobe for the pending flag |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| pix_x | output | FW+3 | Active column |
| pix_y | output | FW+3 | Active row |
| irq | output | 1 | Frame interrupt request |
| irq_pend | output | 1 | Frame interrupt pending flag |

## Verification
The bench builds the block with FW=6 and DW=4. It programs an 11-pixel line and a 7-line frame, so a whole frame takes 77 positions, or 231 cycles at a divisor of 3. Many frame wraps, deferred-divider handovers and every interrupt line selection therefore fit in a short run. A cycle model built from the requirements checks every output on every cycle. Directed checks cover line length under the divider, the mid-frame divider change, polarity while idle and both ways of stopping.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  typedef enum logic [1:0] {
    TRIG_SYNC   = 2'd0,
    TRIG_BPORCH = 2'd1,
    TRIG_ACTIVE = 2'd2,
    TRIG_FPORCH = 2'd3
  } trig_e;
endpackage

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis #(
  parameter int FW = 10,
  parameter int CW = FW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [FW-1:0] sw_m1,
  input  logic [FW-1:0] bp_m1,
  input  logic [FW-1:0] act_m1,
  input  logic [FW-1:0] fp_m1,
  output logic [CW-1:0] pos,
  output logic [CW-1:0] nxt,
  output logic          wrap,
  output logic          in_sync,
  output logic          in_act,
  output logic [CW-1:0] b_bp,
  output logic [CW-1:0] b_act,
  output logic [CW-1:0] b_fp,
  output logic [CW-1:0] offs
);
  function automatic logic [CW-1:0] span(input logic [FW-1:0] m1);
    return CW'(m1) + CW'(1);
  endfunction

  logic [CW-1:0] total;
  logic          last;

  assign b_bp  = span(sw_m1);
  assign b_act = b_bp + span(bp_m1);
  assign b_fp  = b_act + span(act_m1);
  assign total = b_fp + span(fp_m1);

  assign last    = (pos >= total - CW'(1));
  assign nxt     = last ? '0 : pos + CW'(1);
  assign wrap    = inc && last;
  assign in_sync = (pos < b_bp);
  assign in_act  = (pos >= b_act) && (pos < b_fp);
  assign offs    = pos - b_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pos <= '0;
    else if (clr) pos <= '0;
    else if (inc) pos <= nxt;
  end
endmodule

// File: rtl/lcd_tg_clkdiv.sv
module lcd_tg_clkdiv #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic          load,
  input  logic [DW-1:0] div_m1,
  input  logic          sel,
  output logic          tick,
  output logic [DW-1:0] div_sh
);
  logic [DW-1:0] cnt;
  logic          sel_sh;

  assign tick = run && (!sel_sh || (cnt == div_sh));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      div_sh <= '0;
      sel_sh <= 1'b0;
    end else begin
      if (load) begin
        div_sh <= div_m1;
        sel_sh <= sel;
      end
      if (clr || !run || tick) cnt <= '0;
      else                     cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_tg_irq.sv
module lcd_tg_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic gen,
  input  logic fen,
  input  logic ack,
  output logic pend,
  output logic irq
);
  logic set_now;
  assign set_now = evt && gen && fen;
  assign irq     = pend && gen && fen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= (pend && !ack) || set_now;
  end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int FW = 10,
  parameter int DW = 8,
  localparam int CW = FW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] hsw_m1,
  input  logic [FW-1:0] hbp_m1,
  input  logic [FW-1:0] hact_m1,
  input  logic [FW-1:0] hfp_m1,
  input  logic [FW-1:0] vsw_m1,
  input  logic [FW-1:0] vbp_m1,
  input  logic [FW-1:0] vact_m1,
  input  logic [FW-1:0] vfp_m1,
  input  logic [DW-1:0] div_m1,
  input  logic          div_sel,
  input  logic          hs_inv,
  input  logic          vs_inv,
  input  logic          de_inv,
  input  logic          en_now,
  input  logic          en_frm,
  input  logic          irq_glb_en,
  input  logic          irq_frm_en,
  input  logic [1:0]    irq_sel,
  input  logic          irq_ack,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] pix_y,
  output logic          irq,
  output logic          irq_pend
);
  logic          running;
  logic          start, stop, axis_clr, tick;
  logic          h_wrap, v_wrap, f_wrap;
  logic          h_sync, h_act, v_sync, v_act;
  logic          hs_raw, vs_raw, de_raw, evt;
  logic [DW-1:0] div_sh;
  logic [CW-1:0] h_pos, h_nxt, h_bbp, h_bact, h_bfp, h_offs;
  logic [CW-1:0] v_pos, v_nxt, v_bbp, v_bact, v_bfp, v_offs;
  logic [CW-1:0] trig_line;

  // Control events
  assign start    = !running && en_now && en_frm;
  assign f_wrap   = h_wrap && v_wrap;
  assign stop     = !en_now || (f_wrap && !en_frm);
  assign axis_clr = start || stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       running <= 1'b0;
    else if (!en_now) running <= 1'b0;
    else if (start)   running <= 1'b1;
    else if (running && f_wrap && !en_frm) running <= 1'b0;
  end

  lcd_tg_clkdiv #(.DW(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(start || !en_now), .run(running),
    .load(start || f_wrap), .div_m1(div_m1), .sel(div_sel),
    .tick(tick), .div_sh(div_sh)
  );

  lcd_tg_axis #(.FW(FW), .CW(CW)) u_hax (
    .clk(clk), .rst_n(rst_n), .clr(axis_clr), .inc(tick),
    .sw_m1(hsw_m1), .bp_m1(hbp_m1), .act_m1(hact_m1), .fp_m1(hfp_m1),
    .pos(h_pos), .nxt(h_nxt), .wrap(h_wrap), .in_sync(h_sync), .in_act(h_act),
    .b_bp(h_bbp), .b_act(h_bact), .b_fp(h_bfp), .offs(h_offs)
  );

  lcd_tg_axis #(.FW(FW), .CW(CW)) u_vax (
    .clk(clk), .rst_n(rst_n), .clr(axis_clr), .inc(h_wrap),
    .sw_m1(vsw_m1), .bp_m1(vbp_m1), .act_m1(vact_m1), .fp_m1(vfp_m1),
    .pos(v_pos), .nxt(v_nxt), .wrap(v_wrap), .in_sync(v_sync), .in_act(v_act),
    .b_bp(v_bbp), .b_act(v_bact), .b_fp(v_bfp), .offs(v_offs)
  );

  // Frame event line selection
  always_comb begin
    unique case (trig_e'(irq_sel))
      TRIG_SYNC:   trig_line = '0;
      TRIG_BPORCH: trig_line = v_bbp;
      TRIG_ACTIVE: trig_line = v_bact;
      TRIG_FPORCH: trig_line = v_bfp;
      default:     trig_line = '0;
    endcase
  end

  assign evt = (start && (trig_line == '0)) ||
               (running && h_wrap && !stop && (v_nxt == trig_line));

  lcd_tg_irq u_irq (
    .clk(clk), .rst_n(rst_n), .evt(evt), .gen(irq_glb_en), .fen(irq_frm_en),
    .ack(irq_ack), .pend(irq_pend), .irq(irq)
  );

  assign hs_raw = running && h_sync;
  assign vs_raw = running && v_sync;
  assign de_raw = running && h_act && v_act;

  assign hsync = hs_raw ^ hs_inv;
  assign vsync = vs_raw ^ vs_inv;
  assign de    = de_raw ^ de_inv;
  assign pix_x = de_raw ? h_offs : '0;
  assign pix_y = de_raw ? v_offs : '0;
endmodule

// File: rtl/lcd_tg_chk.sv
module lcd_tg_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_now,
  input logic          running,
  input logic          f_wrap,
  input logic [DW-1:0] div_sh,
  input logic          irq,
  input logic          irq_pend,
  input logic          irq_glb_en,
  input logic          irq_frm_en,
  input logic          irq_ack,
  input logic          evt,
  input logic          hs_raw,
  input logic          vs_raw,
  input logic          de_raw
);
  // R7
  stop_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_now |=> !running);

  // R5
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && en_now && !f_wrap) |=> $stable(div_sh));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_glb_en && irq_frm_en) |-> !irq);

  // R11
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !evt) |=> !irq_pend);

  // R3
  de_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de_raw |-> (!hs_raw && !vs_raw));
endmodule

bind lcd_timing_gen lcd_tg_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_now(en_now), .running(running),
  .f_wrap(f_wrap), .div_sh(div_sh), .irq(irq), .irq_pend(irq_pend),
  .irq_glb_en(irq_glb_en), .irq_frm_en(irq_frm_en), .irq_ack(irq_ack),
  .evt(evt), .hs_raw(hs_raw), .vs_raw(vs_raw), .de_raw(de_raw)
);

// File: tb/lcd_timing_gen_test.sv
module lcd_timing_gen_test;
  localparam int FW = 6;
  localparam int DW = 4;
  localparam int CW = FW + 3;
  localparam int HSW = 2, HBP = 3, HACT = 4, HFP = 2;
  localparam int VSW = 1, VBP = 2, VACT = 3, VFP = 1;
  localparam int HT = HSW + HBP + HACT + HFP;
  localparam int VT = VSW + VBP + VACT + VFP;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic [DW-1:0] div_m1 = '0;
  logic div_sel = 1'b0, hs_inv = 1'b0, vs_inv = 1'b0, de_inv = 1'b0;
  logic en_now = 1'b0, en_frm = 1'b0, irq_glb_en = 1'b0, irq_frm_en = 1'b0;
  logic [1:0] irq_sel = 2'd0;
  logic irq_ack = 1'b0;
  logic hsync, vsync, de, irq, irq_pend;
  logic [CW-1:0] pix_x, pix_y;

  lcd_timing_gen #(.FW(FW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .hsw_m1(FW'(HSW-1)), .hbp_m1(FW'(HBP-1)), .hact_m1(FW'(HACT-1)), .hfp_m1(FW'(HFP-1)),
    .vsw_m1(FW'(VSW-1)), .vbp_m1(FW'(VBP-1)), .vact_m1(FW'(VACT-1)), .vfp_m1(FW'(VFP-1)),
    .div_m1(div_m1), .div_sel(div_sel), .hs_inv(hs_inv), .vs_inv(vs_inv), .de_inv(de_inv),
    .en_now(en_now), .en_frm(en_frm), .irq_glb_en(irq_glb_en), .irq_frm_en(irq_frm_en),
    .irq_sel(irq_sel), .irq_ack(irq_ack), .hsync(hsync), .vsync(vsync), .de(de),
    .pix_x(pix_x), .pix_y(pix_y), .irq(irq), .irq_pend(irq_pend)
  );

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  // Scoreboard: model process pushes expected items, monitor pops and compares
  typedef struct {
    bit hs, vs, de, irq, pend;
    int x, y;
  } exp_t;
  exp_t sbq[$];

  bit m_act = 0, m_pend = 0, m_sel = 0;
  int m_h = 0, m_v = 0, m_dc = 0, m_div = 0;

  function automatic int trig_row(input logic [1:0] s);
    case (s)
      2'd0: return 0;
      2'd1: return VSW;
      2'd2: return VSW + VBP;
      default: return VSW + VBP + VACT;
    endcase
  endfunction

  always @(posedge clk) begin
    exp_t e;
    bit ev;
    int per;
    #1;
    ev = 0;
    if (!rst_n) begin
      m_act = 0; m_pend = 0; m_h = 0; m_v = 0; m_dc = 0; m_div = 0; m_sel = 0;
    end else begin
      if (!m_act) begin
        if (en_now && en_frm) begin
          m_act = 1; m_h = 0; m_v = 0; m_dc = 0;
          m_div = int'(div_m1); m_sel = div_sel;
          ev = (trig_row(irq_sel) == 0);
        end
      end else if (!en_now) begin
        m_act = 0; m_h = 0; m_v = 0; m_dc = 0;
      end else begin
        per = m_sel ? m_div + 1 : 1;
        if (m_dc == per - 1) begin
          m_dc = 0;
          m_h++;
          if (m_h == HT) begin
            m_h = 0;
            m_v++;
            if (m_v == VT) begin
              m_v = 0;
              m_div = int'(div_m1); m_sel = div_sel;
              if (!en_frm) m_act = 0;
              else ev = (trig_row(irq_sel) == 0);
            end else begin
              ev = (m_v == trig_row(irq_sel));
            end
          end
        end else begin
          m_dc++;
        end
      end
      m_pend = (m_pend && !irq_ack) || (ev && irq_glb_en && irq_frm_en);
    end
    e.hs = m_act && (m_h < HSW);
    e.vs = m_act && (m_v < VSW);
    e.de = m_act && (m_h >= HSW + HBP) && (m_h < HSW + HBP + HACT)
                 && (m_v >= VSW + VBP) && (m_v < VSW + VBP + VACT);
    e.x  = e.de ? m_h - (HSW + HBP) : 0;
    e.y  = e.de ? m_v - (VSW + VBP) : 0;
    e.pend = m_pend;
    e.irq  = m_pend && irq_glb_en && irq_frm_en;
    sbq.push_back(e);
  end

  always @(negedge clk) begin
    exp_t e;
    if (sbq.size() != 0) begin
      e = sbq.pop_front();
      chk((hsync ^ hs_inv) == e.hs, "R1 hsync", int'(hsync ^ hs_inv), int'(e.hs));
      chk((vsync ^ vs_inv) == e.vs, "R2 vsync", int'(vsync ^ vs_inv), int'(e.vs));
      chk((de ^ de_inv) == e.de, "R3 de", int'(de ^ de_inv), int'(e.de));
      chk(int'(pix_x) == e.x, "R3 pix_x", int'(pix_x), e.x);
      chk(int'(pix_y) == e.y, "R3 pix_y", int'(pix_y), e.y);
      chk(irq_pend == e.pend, "R9 R11 irq_pend", int'(irq_pend), int'(e.pend));
      chk(irq == e.irq, "R10 irq", int'(irq), int'(e.irq));
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Cycles between consecutive rises of raw data enable
  task automatic de_span(output int n);
    bit prev;
    prev = de ^ de_inv;
    forever begin
      @(negedge clk);
      if ((de ^ de_inv) && !prev) break;
      prev = de ^ de_inv;
    end
    n = 0;
    prev = 1;
    forever begin
      @(negedge clk);
      n++;
      if ((de ^ de_inv) && !prev) break;
      prev = de ^ de_inv;
    end
  endtask

  task automatic wait_vs_rise();
    bit prev;
    prev = vsync ^ vs_inv;
    forever begin
      @(negedge clk);
      if ((vsync ^ vs_inv) && !prev) break;
      prev = vsync ^ vs_inv;
    end
  endtask

  task automatic ack_pulse();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    cycles(3);
    // R12 reset state
    chk(hsync == 0 && vsync == 0 && de == 0, "R12 sync/de idle", int'({hsync, vsync, de}), 0);
    chk(irq_pend == 0 && pix_x == 0 && pix_y == 0, "R12 pend/coords", int'(irq_pend), 0);
    rst_n = 1'b1;
    cycles(2);

    // R6 polarity while idle
    hs_inv = 1; vs_inv = 1; de_inv = 1;
    @(posedge clk); #1;
    chk({hsync, vsync, de} == 3'b111, "R6 inverted idle", int'({hsync, vsync, de}), 7);
    @(negedge clk);
    hs_inv = 0; vs_inv = 0; de_inv = 0;

    // R7 start, 1:1 clock, R4
    irq_glb_en = 1; irq_frm_en = 1; irq_sel = 2'd0;
    en_now = 1; en_frm = 1;
    de_span(n);
    chk(n == HT, "R4 R1 line length 1:1", n, HT);
    cycles(2 * HT * VT);

    // R5 mid-frame divider change
    wait_vs_rise();
    div_sel = 1; div_m1 = 4'd2;
    de_span(n);
    chk(n == HT, "R5 old divider held in frame", n, HT);
    wait_vs_rise();
    de_span(n);
    chk(n == HT * 3, "R4 divided line length", n, HT * 3);

    // R6 polarity while running
    hs_inv = 1; vs_inv = 1; de_inv = 1;
    cycles(HT * VT * 3);
    hs_inv = 0; vs_inv = 0; de_inv = 0;

    // R9 each trigger line, with acknowledges (R11)
    for (int s = 1; s < 4; s++) begin
      irq_sel = 2'(s);
      ack_pulse();
      chk(irq_pend == 0, "R11 ack clears pend", int'(irq_pend), 0);
      cycles(HT * VT * 3 + 5);
      chk(irq_pend == 1, "R9 event raised pend", int'(irq_pend), 1);
    end

    // R10 gating
    ack_pulse();
    irq_glb_en = 0;
    cycles(HT * VT * 3 + 5);
    chk(irq_pend == 0 && irq == 0, "R10 global off blocks pend", int'(irq_pend), 0);
    irq_glb_en = 1; irq_frm_en = 0;
    cycles(HT * VT * 3 + 5);
    chk(irq_pend == 0 && irq == 0, "R10 frame off blocks pend", int'(irq_pend), 0);
    irq_frm_en = 1;
    div_sel = 0;

    // R8 deferred stop after frame completes
    wait_vs_rise();
    cycles(5);
    en_frm = 0;
    cycles(3 * HT);
    chk((vsync | hsync | de) == 1, "R8 still running mid-frame", int'({vsync, hsync, de}), 1);
    cycles(HT * VT * 3);
    chk({hsync, vsync, de} == 3'b000 && pix_x == 0, "R8 stopped after frame", int'({hsync, vsync, de}), 0);

    // R7 restart then immediate stop
    en_frm = 1;
    cycles(HT * 4 + 2);
    en_now = 0;
    @(posedge clk); #1;
    chk({hsync, vsync, de} == 3'b000 && pix_x == 0 && pix_y == 0, "R7 immediate stop",
        int'({hsync, vsync, de}), 0);
    cycles(4);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule